// File: doc/BRIEF.md
# Command/Address Parity Guard with Programmable Latency

This block sits between the command/address capture stage of a DDR4-style memory device and the command decoder. It checks even parity on every captured frame and delays the command stream by a programmable parity latency. A frame that fails the check never reaches the decoder. The failing frame is latched for readback, a sticky status flag is raised, and an active-low alert line pulses after a fixed number of clocks. Mode-register writes set the latency code, clear the status flag and choose persistent checking. The block also adds the parity latency into the effective read and write latencies it reports.

Two state machines drive the behaviour. The mode machine has three states: `MODE_OFF` (parity latency zero), `MODE_ARMED` (checking active) and `MODE_HELD` (an error was seen, persistent checking is off and checking is suspended). Its transitions are these. OFF→ARMED or OFF→HELD on an accepted nonzero code; the target is HELD only if the status flag stays set and persistent checking is off. ARMED→HELD on an error or an uncleared flag with persistent checking off. HELD→ARMED when the flag is cleared or persistent checking is turned on. ARMED/HELD→OFF on an accepted zero code.

The alert machine has three states: `AL_IDLE`, `AL_WAIT` (counting the assertion delay) and `AL_LOW` (alert driven low). Its transitions are these. IDLE→WAIT on a detected error. WAIT→LOW when the delay count expires. LOW→IDLE when the pulse width count expires. Any state→IDLE when the mode machine enters OFF.

Top module: `capar_gate`

## Requirements
- R1: The 3-bit latency code maps 0→disabled (0 clocks), 1→4, 2→5, 3→6 and 4→8 clocks. A write of code 5, 6 or 7 is rejected and the current code on `lat_code` is kept.
- R2: A write that would move the code directly from one nonzero value to a different nonzero value is rejected, and the old code is kept. Moves from 0 to nonzero and from nonzero to 0 are accepted.
- R3: Every accepted frame appears on `cmd_valid`/`cmd_bits` unchanged, exactly PL clocks after the clock in which it was presented. With PL = 0 it passes through combinationally in the same cycle.
- R4: A frame fails when the XOR of all `fr_bits` and `fr_par` is 1. A failing frame that is checked never appears on `cmd_valid`.
- R5: `err_status` becomes 1 on the clock edge that samples a failing frame. It stays 1 until a configuration write carries a status field of 0. A write with status field 1 leaves it set.
- R6: `err_frame` holds `{fr_par, fr_bits}` of the most recent failing frame, with the parity bit at the MSB, and changes on no other event.
- R7: With persistent checking off, frames are not checked after an error until the status flag is cleared. Frames with bad parity are then forwarded and do not update `err_frame`.
- R8: With persistent checking on, checking continues while the status flag is set. Later failing frames are suppressed and captured, and passing frames are forwarded.
- R9: After a detected error, `alert_n` goes low ALERT_DLY+1 clock edges after the edge that sampled the frame and stays low for ALERT_PW cycles. Errors detected while a pulse is pending or active do not extend it.
- R10: With code 0, no parity check is made, `err_status` and `err_frame` are unaffected by frames, and `alert_n` stays high. An accepted write of code 0 ends any pending or active alert pulse at that edge.
- R11: `rd_lat` = `add_lat` + `cas_lat` + PL and `wr_lat` = `add_lat` + `cas_wr_lat` + PL, where PL is the clock count of the current code.
- R12: An accepted change of the latency code discards every frame still in flight in the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_valid | input | 1 | A command frame is presented this cycle |
| fr_bits | input | FRAME_W | Command/address frame bits covered by parity |
| fr_par | input | 1 | Parity bit of the frame |
| cfg_wr | input | 1 | Mode-register write strobe |
| cfg_code | input | 3 | Requested latency code |
| cfg_status | input | 1 | Status field written (0 clears the flag) |
| cfg_persist | input | 1 | Persistent checking enable written |
| add_lat | input | LAT_W | Additive latency in clocks |
| cas_lat | input | LAT_W | Read CAS latency in clocks |
| cas_wr_lat | input | LAT_W | Write CAS latency in clocks |
| cmd_valid | output | 1 | Delayed, validated command strobe |
| cmd_bits | output | FRAME_W | Delayed command frame bits |
| alert_n | output | 1 | Active-low parity alert pulse |
| err_status | output | 1 | Sticky parity error flag |
| err_frame | output | FRAME_W+1 | Captured failing frame, parity bit at MSB |
| lat_code | output | 3 | Current latency code |
| rd_lat | output | LAT_W+2 | Effective read latency |
| wr_lat | output | LAT_W+2 | Effective write latency |

## Verification
The properties assume that `rst_n` is held low across at least one clock edge. They also assume a configuration write drives legal widths on every field in the cycle its strobe is high. The sticky-flag and capture properties further assume that a frame and a clearing write arriving together resolve in favour of the error. The stimulus presents no frame in the cycle of a configuration write. Each latency change goes through code 0, except for the writes that deliberately probe rejection. The bench waits for an alert pulse to finish before it starts an error scenario that measures a fresh pulse.

// File: rtl/capar_pkg.sv
`timescale 1ns/1ps
package capar_pkg;

    localparam int CODE_W = 3;
    localparam int MAX_PL = 8;
    localparam int PL_W   = $clog2(MAX_PL + 1);

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_ARMED,
        MODE_HELD
    } mode_e;

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_WAIT,
        AL_LOW
    } alert_e;

    // Codes above 4 are reserved.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return c <= CODE_W'(4);
    endfunction

    function automatic logic [PL_W-1:0] pl_cycles(input logic [CODE_W-1:0] c);
        logic [PL_W-1:0] r;
        case (c)
            3'd1:    r = PL_W'(4);
            3'd2:    r = PL_W'(5);
            3'd3:    r = PL_W'(6);
            3'd4:    r = PL_W'(8);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/capar_parity.sv
`timescale 1ns/1ps
module capar_parity #(
    parameter int FRAME_W = 26
) (
    input  logic               check_en,
    input  logic               fr_valid,
    input  logic [FRAME_W-1:0] fr_bits,
    input  logic               fr_par,
    output logic               par_err
);

    logic odd_ones;

    always_comb begin
        // even parity over the frame and its parity bit
        odd_ones = ^{fr_bits, fr_par};
        par_err  = check_en && fr_valid && odd_ones;
    end

endmodule

// File: rtl/capar_cfg_regs.sv
`timescale 1ns/1ps
module capar_cfg_regs
    import capar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_status,
    input  logic              cfg_persist,
    input  logic              par_err,
    output logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] code_nx,
    output logic              code_change,
    output logic              status_q,
    output logic              status_nx,
    output logic              persist_nx
);

    logic persist_q;
    logic accept;

    always_comb begin
        // only transitions through the disabled code are allowed
        accept = code_legal(cfg_code)
              && ((code_q == '0) || (cfg_code == '0) || (cfg_code == code_q));
        code_nx     = (cfg_wr && accept) ? cfg_code : code_q;
        code_change = (code_nx != code_q);
        persist_nx  = cfg_wr ? cfg_persist : persist_q;
        if (par_err) begin
            status_nx = 1'b1;
        end else if (cfg_wr && !cfg_status) begin
            status_nx = 1'b0;
        end else begin
            status_nx = status_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            persist_q <= 1'b0;
            status_q  <= 1'b0;
        end else begin
            code_q    <= code_nx;
            persist_q <= persist_nx;
            status_q  <= status_nx;
        end
    end

endmodule

// File: rtl/capar_delay_line.sv
`timescale 1ns/1ps
module capar_delay_line #(
    parameter int FRAME_W = 26,
    parameter int DEPTH   = 8,
    parameter int TAP_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_bits,
    input  logic [TAP_W-1:0]   tap,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_bits
);

    logic               vld_q  [DEPTH];
    logic [FRAME_W-1:0] bits_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld_q[i]  <= 1'b0;
                        bits_q[i] <= '0;
                    end else begin
                        vld_q[i]  <= flush ? 1'b0 : in_valid;
                        bits_q[i] <= in_bits;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld_q[i]  <= 1'b0;
                        bits_q[i] <= '0;
                    end else begin
                        vld_q[i]  <= flush ? 1'b0 : vld_q[i-1];
                        bits_q[i] <= bits_q[i-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        out_valid = in_valid;
        out_bits  = in_bits;
        for (int i = 0; i < DEPTH; i++) begin
            if (tap == TAP_W'(i + 1)) begin
                out_valid = vld_q[i];
                out_bits  = bits_q[i];
            end
        end
    end

endmodule

// File: rtl/capar_alert_fsm.sv
`timescale 1ns/1ps
module capar_alert_fsm
    import capar_pkg::*;
#(
    parameter int ALERT_DLY = 2,
    parameter int ALERT_PW  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic abort,
    output logic alert_n
);

    localparam int CNT_MAX = (ALERT_DLY > ALERT_PW) ? ALERT_DLY : ALERT_PW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    alert_e           st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        unique case (st_q)
            AL_IDLE: begin
                if (trigger) begin
                    st_nx  = AL_WAIT;
                    cnt_nx = '0;
                end
            end
            AL_WAIT: begin
                if (cnt_q == CNT_W'(ALERT_DLY - 1)) begin
                    st_nx  = AL_LOW;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            AL_LOW: begin
                if (cnt_q == CNT_W'(ALERT_PW - 1)) begin
                    st_nx  = AL_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            default: begin
                st_nx  = AL_IDLE;
                cnt_nx = '0;
            end
        endcase
        if (abort) begin
            st_nx  = AL_IDLE;
            cnt_nx = '0;
        end
    end

    always_comb begin
        alert_n = (st_q != AL_LOW);
    end

endmodule

// File: rtl/capar_gate.sv
`timescale 1ns/1ps
module capar_gate
    import capar_pkg::*;
#(
    parameter int FRAME_W   = 26,
    parameter int LAT_W     = 5,
    parameter int ALERT_DLY = 2,
    parameter int ALERT_PW  = 48,
    localparam int SUM_W    = LAT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fr_valid,
    input  logic [FRAME_W-1:0] fr_bits,
    input  logic               fr_par,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_code,
    input  logic               cfg_status,
    input  logic               cfg_persist,
    input  logic [LAT_W-1:0]   add_lat,
    input  logic [LAT_W-1:0]   cas_lat,
    input  logic [LAT_W-1:0]   cas_wr_lat,
    output logic               cmd_valid,
    output logic [FRAME_W-1:0] cmd_bits,
    output logic               alert_n,
    output logic               err_status,
    output logic [FRAME_W:0]   err_frame,
    output logic [2:0]         lat_code,
    output logic [SUM_W-1:0]   rd_lat,
    output logic [SUM_W-1:0]   wr_lat
);

    mode_e              mode_q, mode_nx;
    logic               check_en;
    logic               par_err;
    logic [CODE_W-1:0]  code_q, code_nx;
    logic               code_change;
    logic               status_q, status_nx, persist_nx;
    logic [PL_W-1:0]    pl_now;
    logic [FRAME_W:0]   err_frame_q;
    logic               keep_held;

    assign check_en = (mode_q == MODE_ARMED);
    assign pl_now   = pl_cycles(code_q);

    capar_parity #(.FRAME_W(FRAME_W)) u_parity (
        .check_en (check_en),
        .fr_valid (fr_valid),
        .fr_bits  (fr_bits),
        .fr_par   (fr_par),
        .par_err  (par_err)
    );

    capar_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_code    (cfg_code),
        .cfg_status  (cfg_status),
        .cfg_persist (cfg_persist),
        .par_err     (par_err),
        .code_q      (code_q),
        .code_nx     (code_nx),
        .code_change (code_change),
        .status_q    (status_q),
        .status_nx   (status_nx),
        .persist_nx  (persist_nx)
    );

    capar_delay_line #(
        .FRAME_W (FRAME_W),
        .DEPTH   (MAX_PL),
        .TAP_W   (PL_W)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (code_change),
        .in_valid  (fr_valid && !par_err),
        .in_bits   (fr_bits),
        .tap       (pl_now),
        .out_valid (cmd_valid),
        .out_bits  (cmd_bits)
    );

    capar_alert_fsm #(
        .ALERT_DLY (ALERT_DLY),
        .ALERT_PW  (ALERT_PW)
    ) u_alert (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (par_err),
        .abort   (mode_nx == MODE_OFF),
        .alert_n (alert_n)
    );

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_nx;
        end
    end

    // mode next-state logic
    always_comb begin
        keep_held = status_nx && !persist_nx;
        mode_nx   = mode_q;
        unique case (mode_q)
            MODE_OFF: begin
                if (code_nx != '0) begin
                    mode_nx = keep_held ? MODE_HELD : MODE_ARMED;
                end
            end
            MODE_ARMED: begin
                if (code_nx == '0) begin
                    mode_nx = MODE_OFF;
                end else if (keep_held) begin
                    mode_nx = MODE_HELD;
                end
            end
            MODE_HELD: begin
                if (code_nx == '0) begin
                    mode_nx = MODE_OFF;
                end else if (!keep_held) begin
                    mode_nx = MODE_ARMED;
                end
            end
            default: mode_nx = MODE_OFF;
        endcase
    end

    // capture of the failing frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_frame_q <= '0;
        end else if (par_err) begin
            err_frame_q <= {fr_par, fr_bits};
        end
    end

    // outputs
    always_comb begin
        lat_code   = code_q;
        err_status = status_q;
        err_frame  = err_frame_q;
        rd_lat     = SUM_W'(add_lat) + SUM_W'(cas_lat) + SUM_W'(pl_now);
        wr_lat     = SUM_W'(add_lat) + SUM_W'(cas_wr_lat) + SUM_W'(pl_now);
    end

endmodule

// File: rtl/capar_gate_chk.sv
`timescale 1ns/1ps
module capar_gate_chk #(
    parameter int FRAME_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_status,
    input logic             alert_n,
    input logic             err_status,
    input logic [FRAME_W:0] err_frame,
    input logic [2:0]       lat_code
);

    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lat_code <= 3'd4);

    p_no_direct_hop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_code != 3'd0) |=> (lat_code == 3'd0 || lat_code == $past(lat_code)));

    p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !(cfg_wr && !cfg_status)) |=> err_status);

    p_capture_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_frame) |-> err_status);

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_code == 3'd0) |-> alert_n);

endmodule

bind capar_gate capar_gate_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_status (cfg_status),
    .alert_n    (alert_n),
    .err_status (err_status),
    .err_frame  (err_frame),
    .lat_code   (lat_code)
);

// File: tb/capar_gate_tb_top.sv
`timescale 1ns/1ps
module capar_gate_tb_top;

    localparam int FW  = 26;
    localparam int LW  = 5;
    localparam int DLY = 2;
    localparam int PW  = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fr_valid = 1'b0;
    logic [FW-1:0] fr_bits = '0;
    logic          fr_par = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_code = '0;
    logic          cfg_status = 1'b0;
    logic          cfg_persist = 1'b0;
    logic [LW-1:0] add_lat = 5'd3;
    logic [LW-1:0] cas_lat = 5'd11;
    logic [LW-1:0] cas_wr_lat = 5'd9;
    logic          cmd_valid;
    logic [FW-1:0] cmd_bits;
    logic          alert_n;
    logic          err_status;
    logic [FW:0]   err_frame;
    logic [2:0]    lat_code;
    logic [LW+1:0] rd_lat, wr_lat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    capar_gate #(.FRAME_W(FW), .LAT_W(LW), .ALERT_DLY(DLY), .ALERT_PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_bits(fr_bits), .fr_par(fr_par),
        .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_status(cfg_status), .cfg_persist(cfg_persist),
        .add_lat(add_lat), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat),
        .cmd_valid(cmd_valid), .cmd_bits(cmd_bits), .alert_n(alert_n), .err_status(err_status),
        .err_frame(err_frame), .lat_code(lat_code), .rd_lat(rd_lat), .wr_lat(wr_lat)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg(input int code, input bit stat, input bit pers);
        cfg_wr = 1'b1;
        cfg_code = 3'(code);
        cfg_status = stat;
        cfg_persist = pers;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic drive(input bit v, input logic [FW-1:0] b, input bit bad);
        fr_valid = v;
        fr_bits = b;
        fr_par = (^b) ^ bad;
    endtask

    task automatic sweep(input int code, input int lat);
        logic          v_h [40];
        logic [FW-1:0] b_h [40];
        check("R1 code readback", 64'(lat_code), 64'(code));
        check("R11 read latency", 64'(rd_lat), 64'(3 + 11 + lat));
        check("R11 write latency", 64'(wr_lat), 64'(3 + 9 + lat));
        for (int c = 0; c < 40; c++) begin
            v_h[c] = (($urandom % 4) != 0);
            b_h[c] = FW'($urandom);
            drive(v_h[c], b_h[c], 1'b0);
            #1;
            if (c >= lat) begin
                check("R3 delayed valid", 64'(cmd_valid), 64'(v_h[c-lat]));
                if (v_h[c-lat]) check("R3 delayed bits", 64'(cmd_bits), 64'(b_h[c-lat]));
            end else begin
                check("R12 line empty after change", 64'(cmd_valid), 64'd0);
            end
            tick();
        end
        fr_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] bx, by, bz, p1, p2, g, q, r;
        int lows;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick();
        // reset state
        check("R1 reset code", 64'(lat_code), 64'd0);
        check("R10 reset alert", 64'(alert_n), 64'd1);
        check("R5 reset status", 64'(err_status), 64'd0);
        check("R6 reset frame", 64'(err_frame), 64'd0);

        // R3 / R11 sweep over every latency
        cfg(1, 0, 0); sweep(1, 4); cfg(0, 0, 0);
        cfg(2, 0, 0); sweep(2, 5); cfg(0, 0, 0);
        cfg(3, 0, 0); sweep(3, 6); cfg(0, 0, 0);
        cfg(4, 0, 0); sweep(4, 8); cfg(0, 0, 0);
        sweep(0, 0);

        // R4 R5 R6 R9: single error at PL 4
        cfg(1, 0, 0);
        bx = 26'h2a5_5c31;
        drive(1'b1, bx, 1'b1);
        tick();
        fr_valid = 1'b0;
        check("R5 status set", 64'(err_status), 64'd1);
        check("R6 frame captured", 64'(err_frame), 64'({~(^bx), bx}));
        for (int t = 1; t <= DLY + PW + 4; t++) begin
            check("R9 alert timing", 64'(alert_n), 64'(!(t >= DLY + 1 && t <= DLY + PW)));
            check("R4 failing frame dropped", 64'(cmd_valid), 64'd0);
            tick();
        end

        // R7: held, bad frame forwarded and not captured
        by = 26'h13c_0f0e;
        drive(1'b1, by, 1'b1);
        tick();
        fr_valid = 1'b0;
        tick(); tick(); tick();
        check("R7 unchecked frame forwarded", 64'(cmd_valid), 64'd1);
        check("R7 forwarded bits", 64'(cmd_bits), 64'(by));
        check("R7 frame register unchanged", 64'(err_frame), 64'({~(^bx), bx}));
        check("R7 no alert while held", 64'(alert_n), 64'd1);

        // R5: writing 1 keeps, writing 0 clears
        cfg(1, 1, 0);
        check("R5 write of 1 keeps flag", 64'(err_status), 64'd1);
        cfg(1, 0, 0);
        check("R5 write of 0 clears flag", 64'(err_status), 64'd0);
        bz = 26'h3ff_0001;
        drive(1'b1, bz, 1'b1);
        tick();
        fr_valid = 1'b0;
        check("R7 checking resumed", 64'(err_status), 64'd1);
        check("R6 new frame captured", 64'(err_frame), 64'({~(^bz), bz}));
        tick(); tick(); tick();
        check("R4 resumed frame dropped", 64'(cmd_valid), 64'd0);
        repeat (PW + 6) tick();

        // R8 R9: persistent, second error inside pulse
        cfg(1, 0, 1);
        p1 = 26'h055_aa55; p2 = 26'h1a0_3c3c; g = 26'h0f0_f0f0;
        lows = 0;
        for (int t = 0; t < 80; t++) begin
            if (t == 0) drive(1'b1, p1, 1'b1);
            else if (t == 5) drive(1'b1, p2, 1'b1);
            else if (t == 10) drive(1'b1, g, 1'b0);
            else fr_valid = 1'b0;
            #1;
            if (t == 14) begin
                check("R8 good frame forwarded", 64'(cmd_valid), 64'd1);
                check("R8 good frame bits", 64'(cmd_bits), 64'(g));
            end else begin
                check("R8 failing frames dropped", 64'(cmd_valid), 64'd0);
            end
            if (!alert_n) lows++;
            tick();
        end
        fr_valid = 1'b0;
        check("R9 pulse not extended", 64'(lows), 64'(PW));
        check("R8 latest failure captured", 64'(err_frame), 64'({~(^p2), p2}));
        check("R8 flag set", 64'(err_status), 64'd1);

        // R10: disabling aborts pulse, no checks while off
        cfg(1, 0, 0);
        q = 26'h2b2_1d1d;
        drive(1'b1, q, 1'b1);
        tick();
        fr_valid = 1'b0;
        repeat (DLY + 1) tick();
        check("R9 alert low before abort", 64'(alert_n), 64'd0);
        cfg(0, 0, 0);
        check("R10 alert released by disable", 64'(alert_n), 64'd1);
        r = 26'h111_2222;
        drive(1'b1, r, 1'b1);
        #1;
        check("R10 passthrough valid", 64'(cmd_valid), 64'd1);
        check("R10 passthrough bits", 64'(cmd_bits), 64'(r));
        tick();
        fr_valid = 1'b0;
        check("R10 no check when off", 64'(err_status), 64'd0);
        check("R10 frame register untouched", 64'(err_frame), 64'({~(^q), q}));
        for (int t = 0; t < 6; t++) begin
            check("R10 alert high when off", 64'(alert_n), 64'd1);
            tick();
        end

        // R1 R2: code rules
        cfg(5, 0, 0);
        check("R1 reserved rejected", 64'(lat_code), 64'd0);
        cfg(2, 0, 0);
        check("R2 off to nonzero accepted", 64'(lat_code), 64'd2);
        cfg(3, 0, 0);
        check("R2 direct hop rejected", 64'(lat_code), 64'd2);
        check("R11 latency after rejected hop", 64'(rd_lat), 64'(3 + 11 + 5));
        cfg(7, 0, 0);
        check("R1 reserved rejected when on", 64'(lat_code), 64'd2);
        cfg(0, 0, 0);
        check("R2 nonzero to off accepted", 64'(lat_code), 64'd0);
        cfg(4, 0, 0);
        check("R1 code 4", 64'(lat_code), 64'd4);

        // R12: frames in flight discarded by a code change
        drive(1'b1, 26'h0ab_cdef, 1'b0);
        tick();
        fr_valid = 1'b0;
        cfg(0, 0, 0);
        cfg(4, 0, 0);
        for (int t = 0; t < 12; t++) begin
            check("R12 in-flight frame discarded", 64'(cmd_valid), 64'd0);
            tick();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule